// File: doc/BRIEF.md
# Pixel Row Gate/Clear Sequencer

This block walks a pixel matrix one row at a time. For each row it raises that row's select (gate) line, issues a first sample strobe (signal plus pedestal), pulses that row's clear line, and then issues a second sample strobe (pedestal only). Gate and clear lines are two separate one-hot buses, one line per row. The sample strobes go to a current readout front end. During each strobe, the current row index is valid beside the strobe.

Three programmable cycle counts set the phase lengths: how long the gate settles before the first sample, how long the clear lasts, and how long the row recovers before the second sample. The row period can therefore be tuned over a wide range, from a slow scan to a fast one. A frame is started by a pulse and ends with a one-cycle done flag. The next frame follows without a gap when continuous mode is set. Dropping the enable puts the block into a powered-down idle state with every line inactive. This is used between bursts.

Top module: `row_seq_top`

## Requirements
- R1: While reset is high, and after it, all gate and clear lines are 0, no strobe or done is raised, and the row index is 0.
- R2: A start pulse seen with enable high while idle turns on gate line 0 in the following cycle. Rows then follow in ascending order 0..ROWS-1, and at most one gate line is on at any time.
- R3: Each row lasts S+C+R+2 cycles, where S, C and R are the select, clear and recovery counts, and a count of 0 acts as 1. The order within a row is: S cycles of gate only, one cycle of first sample, C cycles of clear, R cycles of recovery, one cycle of second sample. The row's gate stays on for the whole row period.
- R4: A clear line is on only while the gate line of the same row is on, and never in a cycle with a sample strobe.
- R5: Each sample strobe (samp_valid) is high for exactly one cycle. samp_second is 0 on the first sample of a row and 1 on the second. row_idx equals the row whose gate is on.
- R6: The cycle after the second sample of the last row, frame_done is high for one cycle with all gate and clear lines off. If continuous is low in that cycle, the block then returns to idle.
- R7: If continuous is high during the done cycle, gate line 0 turns on in the very next cycle and a new frame runs.
- R8: A start pulse that arrives while a frame is running has no effect on the sequence.
- R9: When enable is low, the next cycle shows all lines off, no strobe, no done, and row index 0. Start is ignored while enable is low. After enable returns, nothing happens until a new start.
- R10: The three counts are captured when a frame begins, so changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low forces powered-down idle |
| start | input | 1 | Frame start pulse |
| continuous | input | 1 | Repeat frames without a gap |
| sel_cycles | input | CNT_W | Gate settle cycles before first sample |
| clr_cycles | input | CNT_W | Clear pulse length in cycles |
| rec_cycles | input | CNT_W | Recovery cycles before second sample |
| gate_bus | output | ROWS | One-hot row gate lines |
| clear_bus | output | ROWS | One-hot row clear lines |
| samp_valid | output | 1 | Single-cycle sample strobe |
| samp_second | output | 1 | 0 = signal+pedestal sample, 1 = pedestal sample |
| row_idx | output | $clog2(ROWS) | Current row |
| frame_done | output | 1 | One-cycle end-of-frame flag |

## Verification
On every cycle, the bound checker enforces the structural rules. At most one gate line is on. Clear lines stay inside the active gate and away from strobes. Strobes and the done flag last a single cycle. The done flag follows the last row's second sample, and disabling blanks the buses. Only the bench scenarios can show the exact phase lengths and row order under several count settings. They also show that zero counts act as one, and that a mid-frame start or count change leaves the timing untouched. Continuous wrap, the stop after clearing continuous, and the restart after power-down are likewise covered only by these scenarios.

// File: rtl/row_seq_pkg.sv
package row_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SELECT,
        PH_SAMP_A,
        PH_CLEAR,
        PH_RECOVER,
        PH_SAMP_B,
        PH_DONE
    } phase_e;

    // A programmed count of zero behaves as one cycle; returns count minus one.
    function automatic logic [15:0] span_m1(input logic [15:0] v);
        return (v == 16'd0) ? 16'd0 : v - 16'd1;
    endfunction

    function automatic logic is_row_active(input phase_e ph);
        return (ph == PH_SELECT) || (ph == PH_SAMP_A) || (ph == PH_CLEAR) ||
               (ph == PH_RECOVER) || (ph == PH_SAMP_B);
    endfunction

endpackage

// File: rtl/row_seq_timer.sv
module row_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/row_seq_ctrl.sv
module row_seq_ctrl
    import row_seq_pkg::*;
#(
    parameter int unsigned ROWS  = 64,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic             continuous,
    input  logic [CNT_W-1:0] sel_cycles,
    input  logic [CNT_W-1:0] clr_cycles,
    input  logic [CNT_W-1:0] rec_cycles,
    input  logic             expired,
    output phase_e           phase,
    output logic [ROW_W-1:0] row,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    phase_e           phase_q, phase_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic [CNT_W-1:0] sel_q, clr_q, rec_q;
    logic             capture;

    function automatic logic [CNT_W-1:0] trim(input logic [CNT_W-1:0] v);
        return CNT_W'(span_m1(16'(v)));
    endfunction

    always_comb begin
        phase_d  = phase_q;
        row_d    = row_q;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    capture  = 1'b1;
                    row_d    = '0;
                    phase_d  = PH_SELECT;
                    load     = 1'b1;
                    load_val = trim(sel_cycles);
                end
            end
            PH_SELECT: begin
                if (expired) phase_d = PH_SAMP_A;
            end
            PH_SAMP_A: begin
                phase_d  = PH_CLEAR;
                load     = 1'b1;
                load_val = clr_q;
            end
            PH_CLEAR: begin
                if (expired) begin
                    phase_d  = PH_RECOVER;
                    load     = 1'b1;
                    load_val = rec_q;
                end
            end
            PH_RECOVER: begin
                if (expired) phase_d = PH_SAMP_B;
            end
            PH_SAMP_B: begin
                if (row_q == LAST_ROW) begin
                    phase_d = PH_DONE;
                end else begin
                    row_d    = row_q + ROW_W'(1);
                    phase_d  = PH_SELECT;
                    load     = 1'b1;
                    load_val = sel_q;
                end
            end
            PH_DONE: begin
                row_d = '0;
                if (continuous) begin
                    capture  = 1'b1;
                    phase_d  = PH_SELECT;
                    load     = 1'b1;
                    load_val = trim(sel_cycles);
                end else begin
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
        if (!enable) begin
            phase_d = PH_IDLE;
            row_d   = '0;
            load    = 1'b0;
            capture = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            row_q   <= '0;
            sel_q   <= '0;
            clr_q   <= '0;
            rec_q   <= '0;
        end else begin
            phase_q <= phase_d;
            row_q   <= row_d;
            if (capture) begin
                sel_q <= trim(sel_cycles);
                clr_q <= trim(clr_cycles);
                rec_q <= trim(rec_cycles);
            end
        end
    end

    assign phase = phase_q;
    assign row   = row_q;
endmodule

// File: rtl/row_seq_lines.sv
module row_seq_lines
    import row_seq_pkg::*;
#(
    parameter int unsigned ROWS = 64,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  phase_e           phase,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  gate_bus,
    output logic [ROWS-1:0]  clear_bus,
    output logic             samp_valid,
    output logic             samp_second,
    output logic             frame_done
);
    logic gate_on, clr_on;

    assign gate_on     = is_row_active(phase);
    assign clr_on      = (phase == PH_CLEAR);
    assign samp_valid  = (phase == PH_SAMP_A) || (phase == PH_SAMP_B);
    assign samp_second = (phase == PH_SAMP_B);
    assign frame_done  = (phase == PH_DONE);

    for (genvar i = 0; i < ROWS; i++) begin : g_line
        logic hit;
        assign hit          = (row == ROW_W'(i));
        assign gate_bus[i]  = gate_on && hit;
        assign clear_bus[i] = clr_on && hit;
    end
endmodule

// File: rtl/row_seq_top.sv
module row_seq_top
    import row_seq_pkg::*;
#(
    parameter int unsigned ROWS  = 64,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             start,
    input  logic             continuous,
    input  logic [CNT_W-1:0] sel_cycles,
    input  logic [CNT_W-1:0] clr_cycles,
    input  logic [CNT_W-1:0] rec_cycles,
    output logic [ROWS-1:0]  gate_bus,
    output logic [ROWS-1:0]  clear_bus,
    output logic             samp_valid,
    output logic             samp_second,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_done
);
    phase_e           phase;
    logic [ROW_W-1:0] row;
    logic             load, expired;
    logic [CNT_W-1:0] load_val;

    row_seq_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst(rst), .enable(enable), .start(start),
        .continuous(continuous), .sel_cycles(sel_cycles),
        .clr_cycles(clr_cycles), .rec_cycles(rec_cycles),
        .expired(expired), .phase(phase), .row(row),
        .load(load), .load_val(load_val)
    );

    row_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .expired(expired)
    );

    row_seq_lines #(.ROWS(ROWS)) lines_i (
        .phase(phase), .row(row), .gate_bus(gate_bus),
        .clear_bus(clear_bus), .samp_valid(samp_valid),
        .samp_second(samp_second), .frame_done(frame_done)
    );

    assign row_idx = row;
endmodule

// File: rtl/row_seq_checker.sv
module row_seq_checker #(
    parameter int unsigned ROWS = 64,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [ROWS-1:0]  gate_bus,
    input logic [ROWS-1:0]  clear_bus,
    input logic             samp_valid,
    input logic             samp_second,
    input logic [ROW_W-1:0] row_idx,
    input logic             frame_done
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    assert_gate_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gate_bus));

    assert_clear_in_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (clear_bus & ~gate_bus) == '0);

    assert_clear_not_sampling_R4: assert property (@(posedge clk) disable iff (rst)
        samp_valid |-> (clear_bus == '0));

    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
        samp_valid |=> !samp_valid);

    assert_strobe_row_R5: assert property (@(posedge clk) disable iff (rst)
        samp_valid |-> gate_bus[row_idx]);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (gate_bus == '0 && clear_bus == '0));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(samp_valid && samp_second && row_idx == LAST_ROW));

    assert_disable_blank_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (gate_bus == '0 && clear_bus == '0 && !samp_valid && !frame_done));
endmodule

bind row_seq_top row_seq_checker #(.ROWS(ROWS)) checker_i (
    .clk(clk), .rst(rst), .enable(enable), .gate_bus(gate_bus),
    .clear_bus(clear_bus), .samp_valid(samp_valid),
    .samp_second(samp_second), .row_idx(row_idx), .frame_done(frame_done)
);

// File: tb/row_seq_top_tb_top.sv
module row_seq_top_tb_top;
    localparam int ROWS  = 64;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst, enable, start, continuous;
    logic [CNT_W-1:0] sel_cycles, clr_cycles, rec_cycles;
    logic [ROWS-1:0]  gate_bus, clear_bus;
    logic             samp_valid, samp_second, frame_done;
    logic [5:0]       row_idx;

    int errors = 0;
    int checks = 0;

    always #5ns clk = ~clk;

    row_seq_top #(.ROWS(ROWS), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .start(start),
        .continuous(continuous), .sel_cycles(sel_cycles),
        .clr_cycles(clr_cycles), .rec_cycles(rec_cycles),
        .gate_bus(gate_bus), .clear_bus(clear_bus), .samp_valid(samp_valid),
        .samp_second(samp_second), .row_idx(row_idx), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_quiet(input string req, input string what);
        check(gate_bus == '0 && clear_bus == '0 && !samp_valid && !frame_done &&
              row_idx == 6'd0, req, what,
              {gate_bus[31:0], clear_bus[31:0]} | 64'(samp_valid) | 64'(frame_done), 64'd0);
    endtask

    // Runs frames from a start pulse and compares every cycle against the
    // timing given by the requirements. disturb: 1 = start mid-frame,
    // 2 = count change mid-frame.
    task automatic scan(input int s, input int c, input int r, input int nframes,
                        input bit cont, input int disturb, input string req);
        int se = (s == 0) ? 1 : s;
        int ce = (c == 0) ? 1 : c;
        int re = (r == 0) ? 1 : r;
        int per = se + ce + re + 2;
        int flen = ROWS * per + 1;
        int total = nframes * flen + 6;
        sel_cycles = CNT_W'(s);
        clr_cycles = CNT_W'(c);
        rec_cycles = CNT_W'(r);
        continuous = cont;
        @(negedge clk);
        start = 1'b1;
        for (int t = 0; t < total; t++) begin
            logic [63:0] eg, ec;
            bit ev, es, ed, rowchk;
            int u, rw, p;
            @(negedge clk);
            eg = '0; ec = '0; ev = 0; es = 0; ed = 0; rowchk = 1; rw = 0;
            if (t < nframes * flen) begin
                u = t % flen;
                if (u == ROWS * per) begin
                    ed = 1; rowchk = 0;
                end else begin
                    rw = u / per;
                    p  = u % per;
                    eg = 64'd1 << rw;
                    if (p == se) ev = 1;
                    if (p > se && p <= se + ce) ec = 64'd1 << rw;
                    if (p == se + ce + re + 1) begin ev = 1; es = 1; end
                end
            end
            check(gate_bus == eg, req, "gate_bus", gate_bus, eg);
            check(clear_bus == ec, req, "clear_bus R4", clear_bus, ec);
            check(samp_valid == ev && samp_second == es, req, "strobe R5",
                  {samp_valid, samp_second}, {ev, es});
            check(frame_done == ed, req, "frame_done R6", 64'(frame_done), 64'(ed));
            if (rowchk)
                check(row_idx == 6'(rw), req, "row_idx R5", 64'(row_idx), 64'(rw));
            if (t == 0) start = 1'b0;
            if (disturb == 1 && t == 40) start = 1'b1;
            if (disturb == 1 && t == 41) start = 1'b0;
            if (disturb == 2 && t == 30) begin
                sel_cycles = CNT_W'(s + 4);
                clr_cycles = CNT_W'(c + 3);
                rec_cycles = CNT_W'(r + 2);
            end
            if (cont && t == (nframes - 1) * flen + 20) continuous = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; enable = 1'b1; start = 1'b0; continuous = 1'b0;
        sel_cycles = '0; clr_cycles = '0; rec_cycles = '0;
        repeat (2) @(negedge clk);
        expect_quiet("R1", "in reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        expect_quiet("R1", "after reset");
    endtask

    task automatic t_basic();       scan(1, 1, 1, 1, 1'b0, 0, "R2 R3 R6"); endtask
    task automatic t_longer();      scan(3, 2, 4, 1, 1'b0, 0, "R3"); endtask
    task automatic t_zero_counts(); scan(0, 0, 0, 1, 1'b0, 0, "R3 zero-as-one"); endtask
    task automatic t_continuous();  scan(2, 1, 1, 2, 1'b1, 0, "R7"); endtask
    task automatic t_start_busy();  scan(1, 2, 1, 1, 1'b0, 1, "R8"); endtask
    task automatic t_count_hold();  scan(2, 1, 3, 1, 1'b0, 2, "R10"); endtask

    task automatic t_power_down();
        sel_cycles = 8'd1; clr_cycles = 8'd1; rec_cycles = 8'd1;
        continuous = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        check(gate_bus != '0, "R9", "running before disable", 64'(gate_bus != '0), 64'd1);
        enable = 1'b0;
        @(negedge clk);
        expect_quiet("R9", "first cycle disabled");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        expect_quiet("R9", "start while disabled");
        enable = 1'b1;
        repeat (4) @(negedge clk);
        expect_quiet("R9", "re-enabled without start");
        continuous = 1'b0;
        scan(1, 1, 2, 1, 1'b0, 0, "R9 restart");
    endtask

    initial begin
        #1ms;
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_longer();
        t_zero_counts();
        t_continuous();
        t_start_busy();
        t_count_hold();
        t_power_down();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule